// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a fail-safe supervisor that software must service at regular intervals. A 16-bit up-counter advances once per prescaler period. The prescaler divides the system clock by one of two ratios, 256 or 16,384, chosen by a select input. Each service strobe loads the counter from a programmable start value and clears the prescaler. The counter therefore overflows after (65536 − start) × ratio system clocks unless software services it first.

Overflow is handled in two steps. The first overflow produces a one-cycle warning interrupt, and the counter restarts from the start value. If a second overflow follows with no service in between, a reset request is raised and held until the block's own reset. Separate single-cycle strobes turn supervision on and off at any time. While supervision is off, the counter and prescaler freeze and no alarms are produced.

Top module: `wdt_guard`

## Requirements
- R1: While and after reset, `count_o` is 0, `prewarn_o` and `rst_req_o` are low, and supervision is on. With `slow_i` low, `count_o` becomes 1 after exactly 256 clock edges following the release of reset.
- R2: With `slow_i` = 0 the counter advances once every 256 clocks. With `slow_i` = 1 it advances once every 16,384 clocks.
- R3: An accepted service strobe loads `count_o` with `reload_i` at the same edge and clears the prescaler. The next increment then comes a full prescaler period later, even when the service lands in the middle of a period.
- R4: At a tick with the counter at 0xFFFF, the counter reloads from `reload_i` instead of wrapping to zero. The time from service to overflow is (65536 − reload) × ratio clocks.
- R5: The first overflow since reset or since the last service drives `prewarn_o` high for exactly one cycle, in the cycle after the overflow edge.
- R6: A second overflow with no service in between drives `rst_req_o` high from the cycle after that edge. It stays high until `rst`, and neither service nor disable clears it.
- R7: A service between the warning and the second overflow cancels the pending reset request. The next overflow then gives a warning again, not a reset request.
- R8: A disable strobe stops counting at its own edge. While disabled, the counter and the prescaler hold their values, service strobes are ignored, and neither output rises. An enable strobe resumes counting from the held prescaler phase at the following edge.
- R9: A disable strobe wins over a service strobe or an enable strobe in the same cycle.
- R10: A service strobe at the very edge where the counter would overflow wins. The counter loads `reload_i` and no warning is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_i | input | 1 | Service strobe, one cycle |
| ena_i | input | 1 | Turn-on strobe, one cycle |
| dis_i | input | 1 | Turn-off strobe, one cycle |
| slow_i | input | 1 | Prescaler select: 0 = divide by 256, 1 = divide by 16,384 |
| reload_i | input | 16 | Start value loaded on service and on overflow |
| prewarn_o | output | 1 | One-cycle warning interrupt at first overflow |
| rst_req_o | output | 1 | Sticky reset request after second overflow |
| count_o | output | 16 | Current counter value |

## Verification
Two pairs of functions can fall in the same cycle. A service can coincide with the overflow tick, and a disable can coincide with a service or an enable. The bench counts prescaler periods from a known service edge so that a service strobe lands exactly on the edge where the count would leave 0xFFFF. It then judges that no warning appears and that the counter holds the start value. Separately, it raises disable together with service, and disable together with enable. It confirms through `count_o` that the count neither reloads nor resumes for hundreds of cycles afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Escalation state of the overflow handler
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WARNED  = 2'd1,
    ST_TRIPPED = 2'd2
  } alarm_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int FAST_DIV = 256,
  parameter int SLOW_DIV = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  input  logic sel,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = sel ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  // >= covers a ratio switch while the phase sits above the fast limit
  assign tick = run && !clr && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (run)  pre_q <= tick ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  assign ovf = tick && !load && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= reload;
    else if (tick)  cnt <= ovf ? reload : cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic svc_ok,
  output logic prewarn,
  output logic rst_req
);
  alarm_e st_q;

  assign rst_req = (st_q == ST_TRIPPED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      prewarn <= 1'b0;
    end else begin
      prewarn <= 1'b0;
      if (st_q != ST_TRIPPED) begin
        if (ovf) begin
          if (st_q == ST_IDLE) begin
            st_q    <= ST_WARNED;
            prewarn <= 1'b1;
          end else begin
            st_q <= ST_TRIPPED;
          end
        end else if (svc_ok) begin
          st_q <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int CNT_W    = 16,
  parameter int FAST_DIV = 256,
  parameter int SLOW_DIV = 16384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_i,
  input  logic             ena_i,
  input  logic             dis_i,
  input  logic             slow_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             prewarn_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] count_o
);
  logic en_q;
  logic run;
  logic svc_ok;
  logic tick;
  logic ovf;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b1;
    else if (dis_i) en_q <= 1'b0;
    else if (ena_i) en_q <= 1'b1;
  end

  assign run    = en_q && !dis_i;
  assign svc_ok = svc_i && run;

  wdt_prescaler #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .clr (svc_ok),
    .sel (slow_i),
    .tick(tick)
  );

  wdt_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .load  (svc_ok),
    .reload(reload_i),
    .cnt   (count_o),
    .ovf   (ovf)
  );

  wdt_alarm u_alm (
    .clk    (clk),
    .rst    (rst),
    .ovf    (ovf),
    .svc_ok (svc_ok),
    .prewarn(prewarn_o),
    .rst_req(rst_req_o)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             svc_i,
  input logic             dis_i,
  input logic             en_q,
  input logic [CNT_W-1:0] reload_i,
  input logic             prewarn_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] count_o
);
  // R6: reset request is sticky
  a_r6_req_sticky: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> rst_req_o);

  // R5: warning lasts a single cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    prewarn_o |=> !prewarn_o);

  // R3: accepted service loads the start value
  a_r3_service_loads: assert property (@(posedge clk) disable iff (rst)
    (svc_i && en_q && !dis_i) |=> (count_o == $past(reload_i)));

  // R8: counter frozen while supervision is off
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_q || dis_i) |=> $stable(count_o));

  // R8: no warning while supervision is off
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_q || dis_i) |=> !prewarn_o);

  // R2/R4: the count only steps by one or reloads
  a_r4_step_or_load: assert property (@(posedge clk) disable iff (rst)
    (count_o != $past(count_o)) |->
      (count_o == CNT_W'($past(count_o) + 1'b1)) || (count_o == $past(reload_i)));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .svc_i    (svc_i),
  .dis_i    (dis_i),
  .en_q     (en_q),
  .reload_i (reload_i),
  .prewarn_o(prewarn_o),
  .rst_req_o(rst_req_o),
  .count_o  (count_o)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        svc_i = 1'b0, ena_i = 1'b0, dis_i = 1'b0, slow_i = 1'b0;
  logic [15:0] reload_i = 16'h0000;
  logic        prewarn_o, rst_req_o;
  logic [15:0] count_o;
  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] held;

  always #10 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst(rst), .svc_i(svc_i), .ena_i(ena_i), .dis_i(dis_i),
    .slow_i(slow_i), .reload_i(reload_i), .prewarn_o(prewarn_o),
    .rst_req_o(rst_req_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int m);
    repeat (m) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic s, input logic e, input logic d);
    svc_i = s; ena_i = e; dis_i = d;
    @(posedge clk);
    @(negedge clk);
    svc_i = 1'b0; ena_i = 1'b0; dis_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    slow_i = 1'b0; reload_i = 16'h0000;
    rst = 1'b1; step(3);
    chk("R1 count in reset", count_o, 0);
    chk("R1 prewarn in reset", prewarn_o, 0);
    chk("R1 rst_req in reset", rst_req_o, 0);
    rst = 1'b0;
    step(255); chk("R1 count before first tick", count_o, 0);
    step(1);   chk("R1 count after first tick", count_o, 1);
  endtask

  task automatic t_service();
    do_reset();
    reload_i = 16'h1234;
    strobe(1, 0, 0);      chk("R3 load", count_o, 16'h1234);
    step(255);            chk("R2 fast no tick yet", count_o, 16'h1234);
    step(1);              chk("R2 fast tick", count_o, 16'h1235);
    step(100);
    strobe(1, 0, 0);      chk("R3 reload mid period", count_o, 16'h1234);
    step(255);            chk("R3 prescaler cleared", count_o, 16'h1234);
    step(1);              chk("R3 full period after clear", count_o, 16'h1235);
  endtask

  task automatic t_escalate();
    do_reset();
    reload_i = 16'hFFFE;
    strobe(1, 0, 0);
    step(511);  chk("R5 no warn early", prewarn_o, 0);
    step(1);    chk("R5 warn pulse", prewarn_o, 1);
                chk("R4 overflow reloads", count_o, 16'hFFFE);
    step(1);    chk("R5 warn one cycle", prewarn_o, 0);
    step(510);  chk("R6 no request early", rst_req_o, 0);
    step(1);    chk("R6 request raised", rst_req_o, 1);
    strobe(1, 0, 0); chk("R6 service keeps request", rst_req_o, 1);
    strobe(0, 0, 1); step(50); chk("R6 disable keeps request", rst_req_o, 1);
  endtask

  task automatic t_cancel();
    do_reset();
    reload_i = 16'hFFFE;
    strobe(1, 0, 0);
    step(512);  chk("R7 first warn", prewarn_o, 1);
    step(88);
    strobe(1, 0, 0);
    step(511);  chk("R7 no request", rst_req_o, 0);
    step(1);    chk("R7 warn again", prewarn_o, 1);
                chk("R7 still no request", rst_req_o, 0);
  endtask

  task automatic t_disable();
    do_reset();
    reload_i = 16'h4000;
    strobe(1, 0, 0);
    step(300);  chk("R8 counted before disable", count_o, 16'h4001);
    strobe(0, 0, 1);
    step(2000); chk("R8 count held", count_o, 16'h4001);
                chk("R8 no request", rst_req_o, 0);
    strobe(1, 0, 0); chk("R8 service ignored", count_o, 16'h4001);
    strobe(0, 1, 0);
    step(211);  chk("R8 prescaler phase held", count_o, 16'h4001);
    step(1);    chk("R8 resumes", count_o, 16'h4002);
    reload_i = 16'h0100;
    strobe(1, 0, 1); chk("R9 disable beats service", count_o, 16'h4002);
    step(1000);      chk("R9 stays disabled", count_o, 16'h4002);
    strobe(0, 1, 1);
    step(600);       chk("R9 disable beats enable", count_o, 16'h4002);
  endtask

  task automatic t_coincide();
    do_reset();
    reload_i = 16'hFFFE;
    strobe(1, 0, 0);
    step(511);
    strobe(1, 0, 0);
    chk("R10 no warn on coincident service", prewarn_o, 0);
    chk("R10 loaded", count_o, 16'hFFFE);
    step(511);  chk("R10 still quiet", prewarn_o, 0);
    step(1);    chk("R10 warn after full interval", prewarn_o, 1);
  endtask

  task automatic t_slow();
    do_reset();
    slow_i = 1'b1; reload_i = 16'hFFFF;
    strobe(1, 0, 0);
    step(16383); chk("R2 slow no overflow yet", prewarn_o, 0);
                 chk("R2 slow count held", count_o, 16'hFFFF);
    step(1);     chk("R2 slow overflow warn", prewarn_o, 1);
    slow_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_service();
    t_escalate();
    t_cancel();
    t_disable();
    t_coincide();
    t_slow();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule